// File: doc/BRIEF.md
# Configuration Monitor Interrupt Controller

This block watches twelve status signals coming from a device that is being configured. It turns selected conditions on them into one interrupt line to the host. Each monitor input first passes through a two-flop synchronizer. Each bit can then be set to evaluate either a level or a transition, and to be active high or active low. A bit also needs its enable bit set before it can take part in status. Conditions that pass enable form the raw status, and conditions that also pass the mask form the masked status. The interrupt output is the OR of the masked status bits.

Software works the block through a small register bus with word addresses. It sets the enable, mask, type and polarity words. It reads the raw and masked status, and it acknowledges edge events by writing ones to an acknowledge register. A separate port register always returns the synchronized input values, so software can sample the live monitor state without any interrupt being set up.

The register map uses these byte offsets: enable 0x00, mask 0x04, type 0x08, polarity 0x0C, masked status 0x10, raw status 0x14, acknowledge 0x18, port 0x1C.

Top module: `cmon_irq_ctrl`

## Requirements
- R1: After reset, the enable, mask, type, polarity, raw status and masked status registers all read zero, and irq_o is low.
- R2: The port register (0x1C) returns the monitor inputs after a two-flop synchronizer, whatever the enable and mask settings are. An input change is not visible in a read whose data is captured on the first clock edge after the change.
- R3: With a type bit of 0 (level mode), the raw status bit equals the enable bit ANDed with the active condition. The input is active when it equals the polarity bit: 1 means active high and 0 means active low. The raw status follows the input.
- R4: With a type bit of 1 (edge mode), a polarity bit of 1 catches a rising transition and a polarity bit of 0 catches a falling transition. The caught event stays in the raw status after the input returns.
- R5: Writing 1 to an acknowledge bit (0x18) clears that bit's edge latch, and bits written 0 leave their latches as they are. In level mode an acknowledge has no lasting effect while the condition persists.
- R6: An enable bit of 0 forces that raw status bit to 0 and discards any edge latch it held. With the enable word at zero, irq_o stays low.
- R7: The masked status equals the raw status ANDed with the inverted mask. A mask bit of 1 blocks that bit.
- R8: irq_o is a registered OR of all masked status bits. It follows the status one clock later.
- R9: The enable, mask, type and polarity registers read back what was written. Writes to the status and port registers have no effect, and the acknowledge register reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; data appears on rdata_o after the next edge |
| addr_i | input | ADDR_W | Byte address, word aligned |
| wdata_i | input | N_MON | Write data |
| rdata_o | output | N_MON | Registered read data |
| mon_i | input | N_MON | Asynchronous monitor inputs |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions check four things on every cycle. Each edge latch goes clear after an acknowledge that had no new event alongside it. A latch rises only from a qualified transition. The interrupt is low one cycle after the enable word was zero or the mask was all ones. The interrupt tracks the OR of the masked status one cycle later. Other behaviour can only be shown by the bench's scenarios. This covers the polarity and type selection for each bit across mixed patterns, the holding of an edge event after the input returns, and acknowledge bits written as zero leaving latches alone. It also covers level conditions outliving an acknowledge, the synchronizer delay seen through the port register, and the read-only registers ignoring writes.

// File: rtl/cmon_pkg.sv
package cmon_pkg;
  // Word index of each register, taken from byte address bits [4:2]
  typedef enum logic [2:0] {
    SEL_EN   = 3'd0,
    SEL_MASK = 3'd1,
    SEL_TYPE = 3'd2,
    SEL_POL  = 3'd3,
    SEL_STAT = 3'd4,
    SEL_RAW  = 3'd5,
    SEL_ACK  = 3'd6,
    SEL_PORT = 3'd7
  } reg_sel_e;

  localparam int unsigned SEL_LSB = 2;
  localparam int unsigned SEL_MSB = 4;
endpackage

// File: rtl/cmon_sync.sv
module cmon_sync #(
  parameter int unsigned WIDTH  = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/cmon_detect.sv
module cmon_detect #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic [WIDTH-1:0] typ_i,
  input  logic [WIDTH-1:0] pol_i,
  input  logic [WIDTH-1:0] ack_i,
  output logic [WIDTH-1:0] raw_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] evt;
  logic [WIDTH-1:0] lvl_act;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sync_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic rise, fall;
    assign rise       = sync_i[i] & ~prev_q[i];
    assign fall       = ~sync_i[i] & prev_q[i];
    assign evt[i]     = pol_i[i] ? rise : fall;
    assign lvl_act[i] = ~(sync_i[i] ^ pol_i[i]);

    always_ff @(posedge clk) begin
      if (rst) latch_q[i] <= 1'b0;
      else     latch_q[i] <= en_i[i] & typ_i[i] &
                             ((latch_q[i] & ~ack_i[i]) | evt[i]);
    end

    assign raw_o[i] = en_i[i] & (typ_i[i] ? latch_q[i] : lvl_act[i]);

    // R5
    latch_ack_chk: assert property (@(posedge clk) disable iff (rst)
      $past(ack_i[i] && !evt[i]) |-> !latch_q[i]);

    // R4
    latch_set_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(latch_q[i]) |-> $past(evt[i] && en_i[i] && typ_i[i]));
  end
endmodule

// File: rtl/cmon_irq_ctrl.sv
module cmon_irq_ctrl
  import cmon_pkg::*;
#(
  parameter int unsigned N_MON       = 12,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_MON-1:0]  wdata_i,
  output logic [N_MON-1:0]  rdata_o,
  input  logic [N_MON-1:0]  mon_i,
  output logic              irq_o
);
  localparam int unsigned HI_LSB = SEL_MSB + 1;

  logic [N_MON-1:0] en_q, mask_q, typ_q, pol_q;
  logic [N_MON-1:0] sync_v, raw_v, masked_v, ack_v, rd_mux;
  logic             hit;
  reg_sel_e         sel;

  assign hit = (addr_i[ADDR_W-1:HI_LSB] == '0) && (addr_i[SEL_LSB-1:0] == '0);
  assign sel = reg_sel_e'(addr_i[SEL_MSB:SEL_LSB]);

  cmon_sync #(.WIDTH(N_MON), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (mon_i),
    .sync_o  (sync_v)
  );

  assign ack_v = (wr_en_i && hit && sel == SEL_ACK) ? wdata_i : '0;

  cmon_detect #(.WIDTH(N_MON)) u_detect (
    .clk    (clk),
    .rst    (rst),
    .sync_i (sync_v),
    .en_i   (en_q),
    .typ_i  (typ_q),
    .pol_i  (pol_q),
    .ack_i  (ack_v),
    .raw_o  (raw_v)
  );

  assign masked_v = raw_v & ~mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mask_q <= '0;
      typ_q  <= '0;
      pol_q  <= '0;
    end else if (wr_en_i && hit) begin
      case (sel)
        SEL_EN:   en_q   <= wdata_i;
        SEL_MASK: mask_q <= wdata_i;
        SEL_TYPE: typ_q  <= wdata_i;
        SEL_POL:  pol_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (sel)
        SEL_EN:   rd_mux = en_q;
        SEL_MASK: rd_mux = mask_q;
        SEL_TYPE: rd_mux = typ_q;
        SEL_POL:  rd_mux = pol_q;
        SEL_STAT: rd_mux = masked_v;
        SEL_RAW:  rd_mux = raw_v;
        SEL_PORT: rd_mux = sync_v;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      if (rd_en_i) rdata_o <= rd_mux;
      irq_o <= |masked_v;
    end
  end

  // R6
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    $past(en_q == '0) |-> !irq_o);

  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    $past(&mask_q) |-> !irq_o);

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $past(masked_v != '0) |-> irq_o);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(masked_v == '0) |-> !irq_o);
endmodule

// File: tb/cmon_irq_ctrl_bench.sv
module cmon_irq_ctrl_bench;
  localparam int N = 12;
  localparam logic [7:0] A_EN = 8'h00, A_MASK = 8'h04, A_TYPE = 8'h08,
    A_POL = 8'h0C, A_STAT = 8'h10, A_RAW = 8'h14, A_ACK = 8'h18, A_PORT = 8'h1C;

  typedef struct packed {
    logic [N-1:0] en, mask, typ, pol, mon, raw, msk;
    logic         irq;
  } vec_t;

  // Level-mode vectors (R3, R7, R8)
  localparam vec_t VECS [6] = '{
    '{12'hFFF, 12'h000, 12'h000, 12'hFFF, 12'h0A5, 12'h0A5, 12'h0A5, 1'b1},
    '{12'h0F0, 12'h000, 12'h000, 12'hFFF, 12'h0FF, 12'h0F0, 12'h0F0, 1'b1},
    '{12'hFFF, 12'hF00, 12'h000, 12'h000, 12'h0F0, 12'hF0F, 12'h00F, 1'b1},
    '{12'hFFF, 12'hFFF, 12'h000, 12'hFFF, 12'hFFF, 12'hFFF, 12'h000, 1'b0},
    '{12'h000, 12'h000, 12'h000, 12'hFFF, 12'hFFF, 12'h000, 12'h000, 1'b0},
    '{12'h00F, 12'h000, 12'h000, 12'h00A, 12'h000, 12'h005, 12'h005, 1'b1}
  };

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]   addr = '0;
  logic [N-1:0] wdata = '0, mon = '0, rdata;
  logic         irq;
  int errors = 0, checks = 0;
  logic [N-1:0] rv;

  always #5 clk = ~clk;

  cmon_irq_ctrl u_cmon_irq_ctrl (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .mon_i(mon), .irq_o(irq));

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(A_EN, rv);   check("R1 enable", rv, '0);
    rd(A_MASK, rv); check("R1 mask", rv, '0);
    rd(A_TYPE, rv); check("R1 type", rv, '0);
    rd(A_POL, rv);  check("R1 polarity", rv, '0);
    rd(A_RAW, rv);  check("R1 raw", rv, '0);
    rd(A_STAT, rv); check("R1 masked", rv, '0);
    check("R1 irq", N'(irq), '0);

    // Vector table walk
    for (int k = 0; k < 6; k++) begin
      wr(A_EN, VECS[k].en);
      wr(A_MASK, VECS[k].mask);
      wr(A_TYPE, VECS[k].typ);
      wr(A_POL, VECS[k].pol);
      mon = VECS[k].mon;
      settle(6);
      rd(A_RAW, rv);  check("R3 raw level", rv, VECS[k].raw);
      rd(A_STAT, rv); check("R7 masked", rv, VECS[k].msk);
      rd(A_PORT, rv); check("R2 port", rv, VECS[k].mon);
      check("R8 irq", N'(irq), N'(VECS[k].irq));
    end

    // R4 rising edge on bit0
    wr(A_TYPE, 12'h001); wr(A_POL, 12'h001); wr(A_EN, 12'h001); wr(A_MASK, 12'h000);
    settle(6);
    rd(A_RAW, rv); check("R4 no edge yet", rv, 12'h000);
    mon = 12'h001; settle(6);
    rd(A_RAW, rv); check("R4 rising caught", rv, 12'h001);
    mon = 12'h000; settle(6);
    rd(A_RAW, rv); check("R4 held after return", rv, 12'h001);
    check("R8 irq on edge", N'(irq), 12'h001);
    wr(A_ACK, 12'h000); settle(2);
    rd(A_RAW, rv); check("R5 zero ack ignored", rv, 12'h001);
    wr(A_ACK, 12'h001); settle(2);
    rd(A_RAW, rv); check("R5 ack clears", rv, 12'h000);
    check("R8 irq drops", N'(irq), 12'h000);

    // R4 falling edge on bit0
    mon = 12'h001; settle(6);
    wr(A_ACK, 12'h001);
    wr(A_POL, 12'h000); settle(2);
    rd(A_RAW, rv); check("R4 clear before fall", rv, 12'h000);
    mon = 12'h000; settle(6);
    rd(A_RAW, rv); check("R4 falling caught", rv, 12'h001);

    // R6 disable drops status and discards latch
    wr(A_EN, 12'h000); settle(2);
    rd(A_RAW, rv); check("R6 disabled raw", rv, 12'h000);
    check("R6 disabled irq", N'(irq), 12'h000);
    wr(A_EN, 12'h001); settle(2);
    rd(A_RAW, rv); check("R6 latch discarded", rv, 12'h000);

    // R5 level persists through ack
    wr(A_TYPE, 12'h000); wr(A_POL, 12'h001);
    mon = 12'h001; settle(6);
    wr(A_ACK, 12'h001); settle(2);
    rd(A_RAW, rv); check("R5 level persists", rv, 12'h001);

    // R9 read-only and readback
    wr(A_STAT, 12'hFFF); wr(A_RAW, 12'hFFF); wr(A_PORT, 12'h000);
    rd(A_PORT, rv); check("R9 port unaffected", rv, 12'h001);
    rd(A_STAT, rv); check("R9 status unaffected", rv, 12'h001);
    rd(A_ACK, rv);  check("R9 ack reads zero", rv, 12'h000);
    wr(A_MASK, 12'h5A5); rd(A_MASK, rv); check("R9 mask readback", rv, 12'h5A5);
    wr(A_TYPE, 12'hA5A); rd(A_TYPE, rv); check("R9 type readback", rv, 12'hA5A);

    // R2 synchronizer delay
    @(negedge clk); mon = 12'h800; rd_en = 1'b1; addr = A_PORT;
    @(negedge clk); rd_en = 1'b0;
    check("R2 not yet visible", rdata, 12'h001);
    settle(3);
    rd(A_PORT, rv); check("R2 visible later", rv, 12'h800);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule